// File: doc/BRIEF.md
# Asynchronous Bus Read-Cycle Sequencer

This block is a bus master that runs one read transfer at a time on a 16-bit asynchronous bus. The bus has an address strobe, a read/write line and separate strobes for the upper and lower byte lanes. The sequencer clock runs at twice the processor clock, so each tick is one half-clock state. A transfer with no wait states takes eight states, S0 to S7. Every output changes in a fixed state, which makes the whole cycle visible at the pins state by state.

A client holds a request with a word address, a byte-lane select and a cycle kind while `reqReady` is high. The sequencer places a 3-bit address-space code on the bus and drives the address, which floats between transfers. It then asserts the strobes and waits for the addressed device to pull the acknowledge low. If the acknowledge comes late, the cycle stretches by whole processor clocks. The sequencer captures the read word near the end of the cycle and reports it with a one-tick done pulse.

Top module: `busReadSeq`

## Requirements
- R1: After reset, and in every idle tick, the outputs are: `addrOe`=0, `asN`=1, `udsN`=1, `ldsN`=1, `rwN`=1, `rdDone`=0, `reqReady`=1. Just after reset `fcOut`=001.
- R2: `fcOut` takes its new value in S0, the first tick after a request is accepted, and holds it for the whole cycle. `reqKind` maps to `fcOut` as follows: 0→001, 1→010, 2→101, 3→110, 4→111. Kinds 5, 6 and 7 map to 001. The codes 000, 011 and 100 never appear.
- R3: `addrOe` is low in idle and in S0, and high from S1 through S7. While `addrOe` is high, `addrOut` equals the accepted `reqAddr` and does not change.
- R4: `asN` goes low in S2, stays low through S6 and through any wait states, and returns high in S7.
- R5: `reqByteSel` bit 1 selects the upper lane (`udsN`) and bit 0 selects the lower lane (`ldsN`). A select of 00 is treated as 11, a word transfer. A selected strobe is low in exactly the ticks where `asN` is low. An unselected strobe stays high.
- R6: `rwN` is high in every tick.
- R7: `dtackN` is sampled at the end of S4. If it is low there, S5 follows, and the whole cycle takes 8 ticks, with `rdDone` in the 8th tick.
- R8: If `dtackN` is high at a sample point, two wait ticks follow and `dtackN` is sampled again at the end of the second one. A cycle with k missed samples therefore lasts 8+2k ticks.
- R9: `rdData` takes the value of `dataIn` at the edge that ends S6. A change of `dataIn` during S7 does not alter the reported word.
- R10: `rdDone` is high for exactly one tick, in S7. `reqReady` is high only in idle. A request raised while a cycle is in progress is ignored and does not start a cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the processor clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Word address of the transfer |
| reqByteSel | input | 2 | Byte lanes: bit 1 upper, bit 0 lower |
| reqKind | input | 3 | Cycle kind that selects the space code |
| reqReady | output | 1 | High when idle and able to accept a request |
| fcOut | output | 3 | Address-space code |
| addrOut | output | ADDR_W | Bus address value |
| addrOe | output | 1 | Address driver enable; low means the address floats |
| asN | output | 1 | Address strobe, active low |
| rwN | output | 1 | Read/write line, high for read |
| udsN | output | 1 | Upper data strobe, active low |
| ldsN | output | 1 | Lower data strobe, active low |
| dtackN | input | 1 | Transfer acknowledge from the device, active low |
| dataIn | input | DATA_W | Read data from the bus |
| rdData | output | DATA_W | Captured read word |
| rdDone | output | 1 | One-tick pulse when a transfer completes |

## Verification
The bench checks every output in every tick of each cycle. A design that moves a signal change by one state, for example strobing in S1 or releasing the strobes in S6, fails on that tick. It runs cycles with zero to three missed acknowledge samples. A design that waits a single tick per miss, or samples the acknowledge in the wrong state, would produce the wrong cycle length and a misplaced done pulse. It scrambles `dataIn` during S7 to catch a capture taken one tick late. It also covers the unused kind codes and the 00 byte select. Finally, it raises a request in the middle of a cycle, which would cause an extra bus cycle if that request were latched.

// File: rtl/busReadPkg.sv
package busReadPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4,
    ST_WA, ST_WB, ST_S5, ST_S6, ST_S7
  } busState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadReq;
    logic driveAddr;
    logic strobeOn;
    logic captureData;
    logic done;
  } dpCtl_t;

  localparam logic [2:0] FC_USER_DATA = 3'b001;
  localparam logic [2:0] FC_USER_PROG = 3'b010;
  localparam logic [2:0] FC_SUP_DATA  = 3'b101;
  localparam logic [2:0] FC_SUP_PROG  = 3'b110;
  localparam logic [2:0] FC_IACK      = 3'b111;

  function automatic logic [2:0] kindToFc(input logic [2:0] kind);
    case (kind)
      3'd1:    return FC_USER_PROG;
      3'd2:    return FC_SUP_DATA;
      3'd3:    return FC_SUP_PROG;
      3'd4:    return FC_IACK;
      default: return FC_USER_DATA;
    endcase
  endfunction

endpackage

// File: rtl/busReadCtl.sv
module busReadCtl
  import busReadPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   dtackN,
  output dpCtl_t ctl,
  output logic   reqReady
);

  busState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) stateNext = ST_S0;
      ST_S0:   stateNext = ST_S1;
      ST_S1:   stateNext = ST_S2;
      ST_S2:   stateNext = ST_S3;
      ST_S3:   stateNext = ST_S4;
      ST_S4:   stateNext = dtackN ? ST_WA : ST_S5;
      ST_WA:   stateNext = ST_WB;
      ST_WB:   stateNext = dtackN ? ST_WA : ST_S5;
      ST_S5:   stateNext = ST_S6;
      ST_S6:   stateNext = ST_S7;
      ST_S7:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.loadReq     = (state == ST_IDLE) && reqValid;
    ctl.driveAddr   = (state != ST_IDLE) && (state != ST_S0);
    ctl.strobeOn    = (state == ST_S2) || (state == ST_S3) || (state == ST_S4) ||
                      (state == ST_WA) || (state == ST_WB) || (state == ST_S5) ||
                      (state == ST_S6);
    ctl.captureData = (state == ST_S6);
    ctl.done        = (state == ST_S7);
    reqReady        = (state == ST_IDLE);
  end

endmodule

// File: rtl/busReadDp.sv
module busReadDp
  import busReadPkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqByteSel,
  input  logic [2:0]        reqKind,
  input  logic [DATA_W-1:0] dataIn,
  output logic [2:0]        fcOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic              asN,
  output logic              rwN,
  output logic              udsN,
  output logic              ldsN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone
);

  logic [ADDR_W-1:0] addrReg;
  logic [1:0]        laneReg;
  logic [2:0]        fcReg;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      laneReg <= 2'b11;
      fcReg   <= FC_USER_DATA;
    end else if (ctl.loadReq) begin
      addrReg <= reqAddr;
      laneReg <= (reqByteSel == 2'b00) ? 2'b11 : reqByteSel;
      fcReg   <= kindToFc(reqKind);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dataReg <= '0;
    else if (ctl.captureData) dataReg <= dataIn;
  end

  assign fcOut   = fcReg;
  assign addrOut = addrReg;
  assign addrOe  = ctl.driveAddr;
  assign asN     = !ctl.strobeOn;
  assign udsN    = !(ctl.strobeOn && laneReg[1]);
  assign ldsN    = !(ctl.strobeOn && laneReg[0]);
  assign rwN     = 1'b1;
  assign rdData  = dataReg;
  assign rdDone  = ctl.done;

endmodule

// File: rtl/busReadSeq.sv
module busReadSeq
  import busReadPkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqByteSel,
  input  logic [2:0]        reqKind,
  output logic              reqReady,
  output logic [2:0]        fcOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic              asN,
  output logic              rwN,
  output logic              udsN,
  output logic              ldsN,
  input  logic              dtackN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone
);

  dpCtl_t ctl;

  busReadCtl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .dtackN(dtackN),
    .ctl(ctl), .reqReady(reqReady)
  );

  busReadDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqAddr(reqAddr), .reqByteSel(reqByteSel), .reqKind(reqKind),
    .dataIn(dataIn), .fcOut(fcOut), .addrOut(addrOut), .addrOe(addrOe),
    .asN(asN), .rwN(rwN), .udsN(udsN), .ldsN(ldsN),
    .rdData(rdData), .rdDone(rdDone)
  );

endmodule

// File: rtl/busReadSeqChk.sv
module busReadSeqChk #(
  parameter int ADDR_W = 23
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        fcOut,
  input logic [ADDR_W-1:0] addrOut,
  input logic              addrOe,
  input logic              asN,
  input logic              rwN,
  input logic              udsN,
  input logic              ldsN,
  input logic              rdDone,
  input logic              reqReady
);

  p_read_line_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    rwN);

  p_strobe_needs_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    !asN |-> addrOe);

  p_lane_with_as_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!udsN || !ldsN) |-> !asN);

  p_fc_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fcOut != 3'b000) && (fcOut != 3'b011) && (fcOut != 3'b100));

  p_fc_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addrOe && $past(addrOe)) |-> $stable(fcOut));

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (addrOe && $past(addrOe)) |-> $stable(addrOut));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone);

  p_as_release_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asN) |-> rdDone);

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!addrOe && asN && !rdDone));

endmodule

bind busReadSeq busReadSeqChk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .fcOut(fcOut), .addrOut(addrOut), .addrOe(addrOe),
  .asN(asN), .rwN(rwN), .udsN(udsN), .ldsN(ldsN), .rdDone(rdDone),
  .reqReady(reqReady)
);

// File: tb/busReadSeq_test.sv
`timescale 1ns/1ps
module busReadSeq_test;

  localparam int ADDR_W = 23;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqByteSel = 2'b11;
  logic [2:0]        reqKind = 3'd0;
  logic              reqReady;
  logic [2:0]        fcOut;
  logic [ADDR_W-1:0] addrOut;
  logic              addrOe, asN, rwN, udsN, ldsN;
  logic              dtackN = 1'b1;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] rdData;
  logic              rdDone;

  int nChecks = 0;
  int nFails  = 0;
  logic [DATA_W-1:0] expQ[$];

  always #10 clk = ~clk;

  busReadSeq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqByteSel(reqByteSel), .reqKind(reqKind), .reqReady(reqReady),
    .fcOut(fcOut), .addrOut(addrOut), .addrOe(addrOe), .asN(asN),
    .rwN(rwN), .udsN(udsN), .ldsN(ldsN), .dtackN(dtackN),
    .dataIn(dataIn), .rdData(rdData), .rdDone(rdDone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] expFc(input logic [2:0] kind);
    case (kind)
      3'd0: return 3'b001;
      3'd1: return 3'b010;
      3'd2: return 3'b101;
      3'd3: return 3'b110;
      3'd4: return 3'b111;
      default: return 3'b001;
    endcase
  endfunction

  task automatic chkIdle(input string tag);
    chk({tag, " R1 reqReady"}, reqReady, 1);
    chk({tag, " R3 addrOe"}, addrOe, 0);
    chk({tag, " R1 asN"}, asN, 1);
    chk({tag, " R1 udsN/ldsN"}, {udsN, ldsN}, 2'b11);
    chk({tag, " R6 rwN"}, rwN, 1);
    chk({tag, " R10 rdDone"}, rdDone, 0);
  endtask

  // monitor: compare each completed read with the scoreboard
  always @(negedge clk) begin
    if (rstN && rdDone) begin
      if (expQ.size() == 0) chk("R10 unexpected done", 1, 0);
      else chk("R9 rdData", rdData, expQ.pop_front());
    end
  end

  task automatic runRead(input logic [ADDR_W-1:0] a, input logic [1:0] sel,
                         input logic [2:0] kind, input int waits,
                         input logic [DATA_W-1:0] d, input bit poke);
    logic [2:0] efc;
    logic eu, el;
    int len;
    bit strobe;
    efc = expFc(kind);
    eu  = sel[1] || (sel == 2'b00);
    el  = sel[0] || (sel == 2'b00);
    len = 8 + 2 * waits;
    expQ.push_back(d);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqByteSel = sel; reqKind = kind; dtackN = 1'b1;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      reqValid = poke && (t == 3);
      if (poke && t == 3) begin
        reqAddr = ~a; reqKind = 3'd4; reqByteSel = 2'b01;
      end
      strobe = (t >= 2) && (t <= len - 2);
      chk("R2 fcOut", fcOut, efc);
      chk("R3 addrOe", addrOe, t >= 1);
      if (t >= 1) chk("R3 addrOut", addrOut, a);
      chk("R4 asN", asN, !strobe);
      chk("R5 udsN", udsN, !(strobe && eu));
      chk("R5 ldsN", ldsN, !(strobe && el));
      chk("R6 rwN", rwN, 1);
      chk(waits == 0 ? "R7 rdDone" : "R8 rdDone", rdDone, t == len - 1);
      chk("R10 reqReady", reqReady, 0);
      dtackN = !((t >= 4 + 2 * waits) && (t < len - 1));
      if (t == len - 2) dataIn = d;
      else if (t == len - 1) dataIn = ~d;
    end
    @(negedge clk);
    reqValid = 1'b0;
    chkIdle("post");
  endtask

  initial begin : watchdog
    #4000000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chkIdle("reset");
    chk("R1 fcOut", fcOut, 3'b001);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("idle");

    runRead(23'h000100, 2'b11, 3'd0, 0, 16'hA5C3, 0);
    runRead(23'h3F0F0F, 2'b01, 3'd1, 1, 16'h1234, 0);
    runRead(23'h7FFFFF, 2'b10, 3'd2, 0, 16'hFFFF, 0);
    runRead(23'h055555, 2'b00, 3'd3, 2, 16'h0001, 0);
    runRead(23'h2AAAAA, 2'b11, 3'd4, 3, 16'hBEEF, 1);
    // request raised mid-cycle must not start a later cycle (R10)
    repeat (3) begin
      @(negedge clk);
      chkIdle("R10 ignored");
    end
    runRead(23'h000000, 2'b01, 3'd5, 0, 16'h8000, 0);
    runRead(23'h123456, 2'b10, 3'd6, 1, 16'h7E7E, 0);
    runRead(23'h654321, 2'b11, 3'd7, 0, 16'h0F0F, 0);

    @(negedge clk);
    chk("R10 all done", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule